// File: doc/BRIEF.md
# Overcharge Delay and Release Controller

This block is the digital timing core of a secondary overcharge monitor for a stack of three to five series cells. Analog comparators outside the block report, for each cell, whether it sits above its overcharge trip level and whether it sits below its release level. The block filters these flags in time and drives one charge-control line, which an external driver stage turns into a gate drive for the charge FET.

All timing runs on a slow oscillator tick enable, nominally one tick per millisecond. A cell that stays above its trip level long enough moves the block into the tripped state. Brief dips in that condition are bridged: the delay count is paused, not restarted. A dip lasting the full reset window discards the count. Leaving the tripped state needs every used cell to be below its release level for a short unbroken interval. A latched test mode, entered by holding a test request, replaces the long trip delay with a short one. It does not shorten the reset window. The undervoltage lockout flag returns everything to the idle state. All comparator, test and lockout flags pass through two-flop synchronizers before use.

Top module: `ovc_guard`

## Requirements
- R1: After reset the block is in normal status and `chargeCut` is at its inactive level: low when `ACTIVE_HIGH` is 1, high when it is 0.
- R2: In normal status, the block enters overcharge status on the tick that completes `BASE_DELAY_TICKS << delaySel` counted ticks during which at least one used cell has its `overFlag` bit set. `delaySel` values 0, 1, 2 and 3 give 1, 2, 4 and 8 times the base delay.
- R3: A run of fewer than `RESET_WIN_TICKS` consecutive ticks with no used cell over its trip level pauses the delay count. Counting resumes from the paused value when a cell trips again.
- R4: `RESET_WIN_TICKS` consecutive ticks with no used cell over its trip level clear the delay count. A later trip starts counting from zero.
- R5: Overcharge status ends on the tick that completes `RELEASE_TICKS` consecutive ticks with every used cell's `underFlag` bit set. Any tick without that condition restarts the release count.
- R6: In normal status, `TEST_ENTRY_TICKS` consecutive ticks with `testReq` high latch test mode. Dropping `testReq` afterwards does not leave test mode.
- R7: In test mode the trip delay is `TEST_DELAY_TICKS` ticks regardless of `delaySel`. The reset window is still `RESET_WIN_TICKS`.
- R8: The test-mode latch clears when overcharge status is entered, so the following trip uses the full delay.
- R9: `uvloFlag` high returns the block to normal status and clears the delay count, the release count and the test-mode latch.
- R10: `chargeCut` equals the overcharge status when `ACTIVE_HIGH` is 1, and its inverse when `ACTIVE_HIGH` is 0.
- R11: Bit i of `overFlag` and `underFlag` belongs to cell i. Bits at positions `NUM_CELLS` and above have no effect on tripping or on release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle pulse from the slow oscillator; all delays are counted in these ticks |
| delaySel | input | 2 | Trip delay multiplier select (1x, 2x, 4x, 8x of the base delay) |
| overFlag | input | 5 | Per-cell flag: cell above its overcharge trip level |
| underFlag | input | 5 | Per-cell flag: cell below its release level |
| testReq | input | 1 | Test-mode entry request level |
| uvloFlag | input | 1 | Supply undervoltage lockout |
| chargeCut | output | 1 | Charge-control output, polarity set by `ACTIVE_HIGH` |

## Verification
A wrong internal count shows at `chargeCut` only as a trip that comes early or late by whole ticks. For this reason the bench compares the output on every tick against a tick-level model and places directed checks on the exact tick before and the tick of each transition. A stuck or missing test latch shows on the next trip as the delay switching between `TEST_DELAY_TICKS` and the full delay. A gap counter that does not reset shows as a trip that arrives many ticks late. Unused-cell leakage is shown by running a four-cell and a five-cell instance side by side on the same flags.

// File: rtl/ovc_pkg.sv
package ovc_pkg;
  localparam int MAX_CELLS = 5;

  typedef enum logic {ST_NORMAL = 1'b0, ST_OVER = 1'b1} ovc_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrDet;
    logic incDet;
    logic clrGap;
    logic incGap;
    logic clrRel;
    logic incRel;
    logic clrTest;
    logic incTest;
    logic useShort;
  } ovc_ctl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic anyOver;
    logic allUnder;
    logic testReq;
    logic uvlo;
    logic detDone;
    logic gapDone;
    logic relDone;
    logic testDone;
  } ovc_sts_t;
endpackage

// File: rtl/ovc_sync.sv
module ovc_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/ovc_datapath.sv
module ovc_datapath
  import ovc_pkg::*;
#(
  parameter int NUM_CELLS        = 5,
  parameter int BASE_DELAY_TICKS = 1000,
  parameter int RESET_WIN_TICKS  = 12,
  parameter int RELEASE_TICKS    = 2,
  parameter int TEST_ENTRY_TICKS = 64,
  parameter int TEST_DELAY_TICKS = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [MAX_CELLS-1:0] overFlag,
  input  logic [MAX_CELLS-1:0] underFlag,
  input  logic                 testReq,
  input  logic                 uvloFlag,
  input  logic [1:0]           delaySel,
  input  ovc_ctl_t             ctl,
  output ovc_sts_t             sts
);
  localparam int LONGEST = (BASE_DELAY_TICKS * 8 > TEST_DELAY_TICKS) ?
                           BASE_DELAY_TICKS * 8 : TEST_DELAY_TICKS;
  localparam int DET_W  = $clog2(LONGEST + 1);
  localparam int GAP_W  = $clog2(RESET_WIN_TICKS + 1);
  localparam int REL_W  = $clog2(RELEASE_TICKS + 1);
  localparam int TST_W  = $clog2(TEST_ENTRY_TICKS + 1);
  localparam int SYNC_W = 2 * MAX_CELLS + 2;

  logic [SYNC_W-1:0]    rawFlags;
  logic [SYNC_W-1:0]    syncFlags;
  logic [MAX_CELLS-1:0] overS;
  logic [MAX_CELLS-1:0] underS;
  logic [MAX_CELLS-1:0] cellMask;
  logic [DET_W-1:0]     detCnt;
  logic [DET_W-1:0]     detLimit;
  logic [GAP_W-1:0]     gapCnt;
  logic [REL_W-1:0]     relCnt;
  logic [TST_W-1:0]     testCnt;

  assign rawFlags = {uvloFlag, testReq, underFlag, overFlag};

  ovc_sync #(.WIDTH(SYNC_W)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(rawFlags),
    .syncOut(syncFlags)
  );

  assign overS  = syncFlags[MAX_CELLS-1:0];
  assign underS = syncFlags[2*MAX_CELLS-1:MAX_CELLS];

  for (genvar c = 0; c < MAX_CELLS; c++) begin : g_mask
    assign cellMask[c] = (c < NUM_CELLS);
  end

  assign detLimit = ctl.useShort ? DET_W'(TEST_DELAY_TICKS)
                                 : (DET_W'(BASE_DELAY_TICKS) << delaySel);

  always_comb begin
    sts.anyOver  = |(overS & cellMask);
    sts.allUnder = &(underS | ~cellMask);
    sts.testReq  = syncFlags[SYNC_W-2];
    sts.uvlo     = syncFlags[SYNC_W-1];
    sts.detDone  = (detCnt + DET_W'(1)) >= detLimit;
    sts.gapDone  = (gapCnt + GAP_W'(1)) >= GAP_W'(RESET_WIN_TICKS);
    sts.relDone  = (relCnt + REL_W'(1)) >= REL_W'(RELEASE_TICKS);
    sts.testDone = (testCnt + TST_W'(1)) >= TST_W'(TEST_ENTRY_TICKS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      detCnt  <= '0;
      gapCnt  <= '0;
      relCnt  <= '0;
      testCnt <= '0;
    end else begin
      if (ctl.clrDet)       detCnt <= '0;
      else if (ctl.incDet)  detCnt <= detCnt + DET_W'(1);
      if (ctl.clrGap)       gapCnt <= '0;
      else if (ctl.incGap)  gapCnt <= gapCnt + GAP_W'(1);
      if (ctl.clrRel)       relCnt <= '0;
      else if (ctl.incRel)  relCnt <= relCnt + REL_W'(1);
      if (ctl.clrTest)      testCnt <= '0;
      else if (ctl.incTest) testCnt <= testCnt + TST_W'(1);
    end
  end
endmodule

// File: rtl/ovc_control.sv
module ovc_control
  import ovc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     tickEn,
  input  ovc_sts_t sts,
  output ovc_ctl_t ctl,
  output logic     inOver,
  output logic     testLatch
);
  ovc_state_e state, stateNext;
  logic armed, armedNext;
  logic latchNext;

  always_comb begin
    ctl          = '0;
    ctl.useShort = testLatch;
    stateNext    = state;
    armedNext    = armed;
    latchNext    = testLatch;
    if (sts.uvlo) begin
      ctl.clrDet  = 1'b1;
      ctl.clrGap  = 1'b1;
      ctl.clrRel  = 1'b1;
      ctl.clrTest = 1'b1;
      stateNext   = ST_NORMAL;
      armedNext   = 1'b0;
      latchNext   = 1'b0;
    end else if (tickEn) begin
      case (state)
        ST_NORMAL: begin
          if (sts.testReq) begin
            if (sts.testDone) begin
              latchNext   = 1'b1;
              ctl.clrTest = 1'b1;
            end else begin
              ctl.incTest = 1'b1;
            end
          end else begin
            ctl.clrTest = 1'b1;
          end
          if (sts.anyOver) begin
            ctl.clrGap = 1'b1;
            if (sts.detDone) begin
              stateNext  = ST_OVER;
              armedNext  = 1'b0;
              latchNext  = 1'b0;
              ctl.clrDet = 1'b1;
              ctl.clrRel = 1'b1;
            end else begin
              ctl.incDet = 1'b1;
              armedNext  = 1'b1;
            end
          end else if (armed) begin
            if (sts.gapDone) begin
              armedNext  = 1'b0;
              ctl.clrDet = 1'b1;
              ctl.clrGap = 1'b1;
            end else begin
              ctl.incGap = 1'b1;
            end
          end
        end
        ST_OVER: begin
          ctl.clrTest = 1'b1;
          if (sts.allUnder) begin
            if (sts.relDone) begin
              stateNext  = ST_NORMAL;
              ctl.clrRel = 1'b1;
            end else begin
              ctl.incRel = 1'b1;
            end
          end else begin
            ctl.clrRel = 1'b1;
          end
        end
        default: stateNext = ST_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_NORMAL;
      armed     <= 1'b0;
      testLatch <= 1'b0;
    end else begin
      state     <= stateNext;
      armed     <= armedNext;
      testLatch <= latchNext;
    end
  end

  assign inOver = (state == ST_OVER);
endmodule

// File: rtl/ovc_guard.sv
module ovc_guard
  import ovc_pkg::*;
#(
  parameter int NUM_CELLS        = 5,
  parameter bit ACTIVE_HIGH      = 1'b1,
  parameter int BASE_DELAY_TICKS = 1000,
  parameter int RESET_WIN_TICKS  = 12,
  parameter int RELEASE_TICKS    = 2,
  parameter int TEST_ENTRY_TICKS = 64,
  parameter int TEST_DELAY_TICKS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic [1:0] delaySel,
  input  logic [4:0] overFlag,
  input  logic [4:0] underFlag,
  input  logic       testReq,
  input  logic       uvloFlag,
  output logic       chargeCut
);
  ovc_ctl_t ctl;
  ovc_sts_t sts;
  logic     inOver;
  logic     testLatch;

  ovc_datapath #(
    .NUM_CELLS       (NUM_CELLS),
    .BASE_DELAY_TICKS(BASE_DELAY_TICKS),
    .RESET_WIN_TICKS (RESET_WIN_TICKS),
    .RELEASE_TICKS   (RELEASE_TICKS),
    .TEST_ENTRY_TICKS(TEST_ENTRY_TICKS),
    .TEST_DELAY_TICKS(TEST_DELAY_TICKS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .overFlag (overFlag),
    .underFlag(underFlag),
    .testReq  (testReq),
    .uvloFlag (uvloFlag),
    .delaySel (delaySel),
    .ctl      (ctl),
    .sts      (sts)
  );

  ovc_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .sts      (sts),
    .ctl      (ctl),
    .inOver   (inOver),
    .testLatch(testLatch)
  );

  if (ACTIVE_HIGH) begin : g_pol_high
    assign chargeCut = inOver;
  end else begin : g_pol_low
    assign chargeCut = ~inOver;
  end
endmodule

// File: rtl/ovc_guard_chk.sv
module ovc_guard_chk
  import ovc_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     tickEn,
  input logic     chargeCut,
  input logic     inOver,
  input logic     testLatch,
  input ovc_sts_t sts
);
  // R10: the output moves only on a tick or on lockout
  assert_cut_moves_on_tick_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(chargeCut) |-> ($past(tickEn) || $past(sts.uvlo)));

  // R2: trip needs a completed count while a cell was over
  assert_trip_needs_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inOver) |-> ($past(tickEn) && $past(sts.anyOver) && $past(sts.detDone)));

  // R5: release needs a completed release count unless lockout forced it
  assert_release_needs_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(inOver) && !$past(sts.uvlo)) |-> ($past(sts.allUnder) && $past(sts.relDone)));

  // R8: entering overcharge drops the test latch
  assert_trip_clears_test_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inOver) |-> !testLatch);

  // R9: lockout leaves the block idle
  assert_uvlo_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(sts.uvlo) |-> (!inOver && !testLatch));

  // R6: the latch sets only after a held request in normal status
  assert_test_entry_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testLatch) |-> ($past(sts.testReq) && $past(sts.testDone) && !inOver));
endmodule

bind ovc_guard ovc_guard_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .chargeCut(chargeCut),
  .inOver   (inOver),
  .testLatch(testLatch),
  .sts      (sts)
);

// File: tb/tb_ovc_guard.sv
`timescale 1ns/1ps
module tb_ovc_guard;
  localparam int BASE  = 20;
  localparam int WIN   = 6;
  localparam int REL   = 2;
  localparam int ENTRY = 10;
  localparam int TDLY  = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [1:0] delaySel = 2'd0;
  logic [4:0] overFlag = '0;
  logic [4:0] underFlag = '0;
  logic       testReq = 1'b0;
  logic       uvloFlag = 1'b0;
  logic       cut0, cut1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // model state, index 0: four cells active-low, index 1: five cells active-high
  bit mOver[2], mArmed[2], mLatch[2];
  int mDet[2], mGap[2], mRel[2], mTc[2];

  always #5 clk = ~clk;

  ovc_guard #(.NUM_CELLS(4), .ACTIVE_HIGH(1'b0), .BASE_DELAY_TICKS(BASE),
    .RESET_WIN_TICKS(WIN), .RELEASE_TICKS(REL), .TEST_ENTRY_TICKS(ENTRY),
    .TEST_DELAY_TICKS(TDLY)) dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .delaySel(delaySel),
    .overFlag(overFlag), .underFlag(underFlag), .testReq(testReq),
    .uvloFlag(uvloFlag), .chargeCut(cut0));

  ovc_guard #(.NUM_CELLS(5), .ACTIVE_HIGH(1'b1), .BASE_DELAY_TICKS(BASE),
    .RESET_WIN_TICKS(WIN), .RELEASE_TICKS(REL), .TEST_ENTRY_TICKS(ENTRY),
    .TEST_DELAY_TICKS(TDLY)) dut2 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .delaySel(delaySel),
    .overFlag(overFlag), .underFlag(underFlag), .testReq(testReq),
    .uvloFlag(uvloFlag), .chargeCut(cut1));

  function automatic logic [4:0] maskOf(int k);
    return (k == 0) ? 5'b01111 : 5'b11111;
  endfunction

  task automatic modelStep(int k, logic [4:0] ov, logic [4:0] un, bit tr, bit uv);
    bit anyO, allU, newLatch;
    int lim;
    if (uv) begin
      mOver[k] = 0; mArmed[k] = 0; mLatch[k] = 0;
      mDet[k] = 0; mGap[k] = 0; mRel[k] = 0; mTc[k] = 0;
      return;
    end
    anyO = |(ov & maskOf(k));
    allU = &(un | ~maskOf(k));
    if (!mOver[k]) begin
      lim = mLatch[k] ? TDLY : (BASE << delaySel);
      newLatch = mLatch[k];
      if (tr) begin
        if (mTc[k] + 1 >= ENTRY) begin newLatch = 1; mTc[k] = 0; end
        else mTc[k]++;
      end else mTc[k] = 0;
      if (anyO) begin
        mGap[k] = 0;
        if (mDet[k] + 1 >= lim) begin
          mOver[k] = 1; mArmed[k] = 0; mDet[k] = 0; newLatch = 0; mRel[k] = 0;
        end else begin
          mDet[k]++; mArmed[k] = 1;
        end
      end else if (mArmed[k]) begin
        if (mGap[k] + 1 >= WIN) begin mArmed[k] = 0; mDet[k] = 0; mGap[k] = 0; end
        else mGap[k]++;
      end
      mLatch[k] = newLatch;
    end else begin
      mTc[k] = 0;
      if (allU) begin
        if (mRel[k] + 1 >= REL) begin mOver[k] = 0; mRel[k] = 0; end
        else mRel[k]++;
      end else mRel[k] = 0;
    end
  endtask

  task automatic checkOut(bit e0, bit e1, string lab);
    bit a0, a1;
    a0 = ~cut0;
    a1 = cut1;
    checks++;
    if (a0 !== e0 || a1 !== e1) begin
      failures++;
      $display("FAIL %s: overcharge actual=%0b/%0b expected=%0b/%0b", lab, a0, a1, e0, e1);
    end
  endtask

  task automatic step(logic [4:0] ov, logic [4:0] un, bit tr, bit uv, string lab);
    @(negedge clk);
    overFlag = ov; underFlag = un; testReq = tr; uvloFlag = uv;
    repeat (6) @(negedge clk);
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    modelStep(0, ov, un, tr, uv);
    modelStep(1, ov, un, tr, uv);
    checkOut(mOver[0], mOver[1], lab);
  endtask

  task automatic run(int n, logic [4:0] ov, logic [4:0] un, bit tr, bit uv, string lab);
    for (int i = 0; i < n; i++) step(ov, un, tr, uv, lab);
  endtask

  task automatic releaseAll();
    run(REL, 5'b0, 5'b11111, 1'b0, 1'b0, "R5 release");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [4:0] rOv, rUn;
    bit rTr, rUv;
    int burst;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1, R10: idle polarity after reset
    checkOut(1'b0, 1'b0, "R1 reset state");
    checks++;
    if (cut0 !== 1'b1 || cut1 !== 1'b0) begin
      failures++;
      $display("FAIL R10: cut actual=%0b/%0b expected=1/0", cut0, cut1);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2: base delay
    run(BASE - 1, 5'b00001, 5'b0, 0, 0, "R2 before trip");
    checkOut(1'b0, 1'b0, "R2 one tick short");
    step(5'b00001, 5'b0, 0, 0, "R2 trip");
    checkOut(1'b1, 1'b1, "R2 trip tick");
    checks++;
    if (cut0 !== 1'b0 || cut1 !== 1'b1) begin
      failures++;
      $display("FAIL R10: cut actual=%0b/%0b expected=0/1", cut0, cut1);
    end
    // R5: broken release restarts
    step(5'b0, 5'b11111, 0, 0, "R5 first");
    step(5'b0, 5'b0, 0, 0, "R5 broken");
    step(5'b0, 5'b11111, 0, 0, "R5 restart");
    checkOut(1'b1, 1'b1, "R5 still over after restart");
    step(5'b0, 5'b11111, 0, 0, "R5 done");
    checkOut(1'b0, 1'b0, "R5 released");

    // R3: short gap pauses
    run(10, 5'b00010, 5'b0, 0, 0, "R3 first run");
    run(WIN - 1, 5'b0, 5'b0, 0, 0, "R3 gap");
    run(BASE - 11, 5'b00100, 5'b0, 0, 0, "R3 resume");
    checkOut(1'b0, 1'b0, "R3 one short");
    step(5'b00100, 5'b0, 0, 0, "R3 trip");
    checkOut(1'b1, 1'b1, "R3 paused count kept");
    releaseAll();

    // R4: full gap clears
    run(10, 5'b01000, 5'b0, 0, 0, "R4 first run");
    run(WIN, 5'b0, 5'b0, 0, 0, "R4 gap");
    run(BASE - 1, 5'b01000, 5'b0, 0, 0, "R4 recount");
    checkOut(1'b0, 1'b0, "R4 count was cleared");
    step(5'b01000, 5'b0, 0, 0, "R4 trip");
    checkOut(1'b1, 1'b1, "R4 trip after full count");
    releaseAll();

    // R11: unused cell ignored
    run(BASE + 5, 5'b10000, 5'b0, 0, 0, "R11 cell4 over");
    checkOut(1'b0, 1'b1, "R11 cell4 only trips five-cell");
    run(REL + 1, 5'b10000, 5'b01111, 0, 0, "R11 hold");
    checkOut(1'b0, 1'b1, "R11 five-cell holds");
    releaseAll();
    run(BASE, 5'b00001, 5'b0, 0, 0, "R11 both trip");
    run(REL, 5'b0, 5'b01111, 0, 0, "R11 partial under");
    checkOut(1'b0, 1'b1, "R11 unused under bit ignored");
    releaseAll();

    // R2: longer selects
    delaySel = 2'd2;
    run(4 * BASE - 1, 5'b00001, 5'b0, 0, 0, "R2 sel2");
    checkOut(1'b0, 1'b0, "R2 sel2 short");
    step(5'b00001, 5'b0, 0, 0, "R2 sel2 trip");
    checkOut(1'b1, 1'b1, "R2 sel2 trip");
    releaseAll();
    delaySel = 2'd3;
    run(8 * BASE - 1, 5'b00010, 5'b0, 0, 0, "R2 sel3");
    checkOut(1'b0, 1'b0, "R2 sel3 short");
    step(5'b00010, 5'b0, 0, 0, "R2 sel3 trip");
    checkOut(1'b1, 1'b1, "R2 sel3 trip");
    releaseAll();
    delaySel = 2'd0;

    // R6, R7: test mode latches and shortens
    run(ENTRY, 5'b0, 5'b0, 1, 0, "R6 entry");
    run(3, 5'b0, 5'b0, 0, 0, "R6 request dropped");
    run(TDLY - 1, 5'b00001, 5'b0, 0, 0, "R7 short delay");
    checkOut(1'b0, 1'b0, "R7 one short");
    step(5'b00001, 5'b0, 0, 0, "R7 trip");
    checkOut(1'b1, 1'b1, "R6 latch held, R7 short trip");
    releaseAll();
    // R8: latch gone after trip
    run(BASE - 1, 5'b00001, 5'b0, 0, 0, "R8 full delay");
    checkOut(1'b0, 1'b0, "R8 latch cleared by trip");
    step(5'b00001, 5'b0, 0, 0, "R8 trip");
    releaseAll();
    // R7: reset window not shortened
    run(ENTRY, 5'b0, 5'b0, 1, 0, "R7 entry");
    run(2, 5'b00001, 5'b0, 0, 0, "R7 run");
    run(WIN - 1, 5'b0, 5'b0, 0, 0, "R7 gap");
    run(TDLY - 3, 5'b00001, 5'b0, 0, 0, "R7 resume");
    checkOut(1'b0, 1'b0, "R7 one short");
    step(5'b00001, 5'b0, 0, 0, "R7 trip");
    checkOut(1'b1, 1'b1, "R7 window unchanged in test mode");
    releaseAll();

    // R8, R9: lockout clears latch, count and status
    run(ENTRY, 5'b0, 5'b0, 1, 0, "R9 entry");
    step(5'b0, 5'b0, 0, 1, "R9 lockout");
    run(BASE - 1, 5'b00001, 5'b0, 0, 0, "R9 full delay");
    checkOut(1'b0, 1'b0, "R8 latch cleared by lockout");
    step(5'b00001, 5'b0, 0, 0, "R9 trip");
    releaseAll();
    run(15, 5'b00001, 5'b0, 0, 0, "R9 partial");
    step(5'b00001, 5'b0, 0, 1, "R9 lockout mid count");
    run(BASE - 1, 5'b00001, 5'b0, 0, 0, "R9 recount");
    checkOut(1'b0, 1'b0, "R9 count cleared");
    step(5'b00001, 5'b0, 0, 0, "R9 trip");
    checkOut(1'b1, 1'b1, "R9 trip");
    step(5'b00001, 5'b0, 0, 1, "R9 lockout in overcharge");
    checkOut(1'b0, 1'b0, "R9 forced normal");
    step(5'b0, 5'b0, 0, 0, "R9 idle");

    // random phase, checked against the model (R2..R11)
    rOv = '0; rUn = '0; rTr = 0; burst = 0;
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(7) == 0) begin
        case ($urandom_range(3))
          0: rOv = '0;
          1: rOv = 5'b1 << $urandom_range(4);
          2: rOv = 5'($urandom);
          default: rOv = 5'b00001;
        endcase
        rUn = ($urandom_range(2) == 0) ? 5'($urandom) : 5'b11111;
      end
      if (burst == 0 && $urandom_range(99) == 0) burst = ENTRY + 2;
      rTr = (burst > 0);
      if (burst > 0) burst--;
      rUv = ($urandom_range(199) == 0);
      if ($urandom_range(299) == 0) delaySel = 2'($urandom_range(1));
      step(rOv, rUn, rTr, rUv, "R2 random vs model");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule